// File: doc/BRIEF.md
# Level-Sensitive Vectored Interrupt Controller

The block gathers 32 level-sensitive request lines and reports them to a processor core. It gives the core three signals: an interrupt request wire, an 8-bit vector bus and a non-maskable request wire. Lines 1 to 29 are ordinary sources. Each one drives a raw pending bit and is gated by a mask register that software writes. Lines 30 and 31 skip the mask and feed a non-maskable status register. Line 0 has no effect.

The block does not arbitrate between ordinary sources. One enabled pending source gets a vector of its own. Two or more enabled pending sources share one common vector, and the handler reads the enabled-pending register to decide which to serve. A small word-wide register port gives access to the mask, the raw pending bits, the enabled-pending bits, the non-maskable status and a diagnostic word that always reads as zero. All inputs are sampled on the clock. The outputs are registered and follow an input or mask change one cycle later.

Top module: `vic_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the mask, the raw pending bits and the non-maskable status. After reset, irq_req and nmi_req are 0, irq_vec is 0x00 and every register reads 0.
- R2: A write changes the mask only when wr_en is high and addr is byte 0. A write to any other address, including a byte address that is not a multiple of 4, changes no register.
- R3: A read with rd_en high at byte address 0, 4, 8, 12 or 16 returns, in the next cycle, the mask, the raw pending bits, the enabled-pending bits, the non-maskable status or zero, in that order. Any other address, and any cycle without rd_en, gives rd_data 0.
- R4: The enabled-pending register always equals the raw pending register ANDed bitwise with the mask.
- R5: When no enabled-pending bit is set, irq_vec is 0x00 and irq_req is 0.
- R6: When exactly one enabled-pending bit is set, at position i (0 to 30), irq_vec is 0x31 + i and irq_req is 1.
- R7: When two or more enabled-pending bits are set, irq_vec is 0x30 and irq_req is 1.
- R8: Line n, for n from 1 to 29, sets raw pending bit n-1 to its current level on every clock. Line 0 changes nothing.
- R9: Lines 30 and 31 set status bits 30 and 31 to their current levels on every clock, whatever the mask holds. nmi_req is the OR of the status bits and does not depend on the mask.
- R10: irq_vec, irq_req and nmi_req reflect the input lines and the mask write of the previous clock edge. The change shows in the cycle right after that edge, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive request lines |
| addr | input | 5 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq_req | output | 1 | Maskable interrupt request |
| irq_vec | output | 8 | Interrupt vector |
| nmi_req | output | 1 | Non-maskable request |

## Verification
On every cycle the assertions check the vector code against the number of enabled-pending bits: none, exactly one, or several. They also check that irq_req agrees with the vector, that the raw and non-maskable status registers follow the lines with a one-cycle delay, and that the mask changes only on a write to byte 0. The bench scenarios cover the rest. They cover the register read map and its zero-reading addresses, and the fact that line 0 and misaligned writes do nothing. They also show the exact cycle in which the outputs move, and the end positions of the scan, such as line 29 producing vector 0x4D.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Word indices of the register port; byte address is index * 4.
  typedef enum logic [2:0] {
    IDX_MASK = 3'd0,
    IDX_RAW  = 3'd1,
    IDX_ENAB = 3'd2,
    IDX_NMI  = 3'd3,
    IDX_DIAG = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/vic_src.sv
module vic_src #(
  parameter int N_LINES   = 32,
  parameter int NMI_FIRST = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  output logic [N_LINES-1:0] raw_d,
  output logic [N_LINES-1:0] nmi_d,
  output logic [N_LINES-1:0] raw_q,
  output logic [N_LINES-1:0] nmi_q
);
  // Line 0 has no pending bit.
  logic unused_line0;
  assign unused_line0 = irq_in[0];

  for (genvar i = 0; i < N_LINES; i++) begin : g_bit
    if (i < NMI_FIRST - 1) begin : g_norm
      assign raw_d[i] = irq_in[i+1];
    end else begin : g_none
      assign raw_d[i] = 1'b0;
    end
    if (i >= NMI_FIRST) begin : g_nmi
      assign nmi_d[i] = irq_in[i];
    end else begin : g_nonmi
      assign nmi_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      nmi_q <= '0;
    end else begin
      raw_q <= raw_d;
      nmi_q <= nmi_d;
    end
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] raw_q,
  input  logic [DATA_W-1:0] nmi_q,
  output logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             mask_hit;
  logic [DATA_W-1:0] rd_sel;

  assign aligned  = (addr[1:0] == 2'b00);
  assign idx      = addr[ADDR_W-1:2];
  assign mask_hit = wr_en && aligned && (idx == IDX_W'(IDX_MASK));
  assign mask_d   = mask_hit ? wr_data : mask_q;

  always_comb begin
    rd_sel = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(IDX_MASK): rd_sel = mask_q;
        IDX_W'(IDX_RAW):  rd_sel = raw_q;
        IDX_W'(IDX_ENAB): rd_sel = raw_q & mask_q;
        IDX_W'(IDX_NMI):  rd_sel = nmi_q;
        default:          rd_sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rd_data <= '0;
    end else begin
      mask_q  <= mask_d;
      rd_data <= rd_en ? rd_sel : '0;
    end
  end
endmodule

// File: rtl/vic_encode.sv
module vic_encode #(
  parameter int         N_LINES = 32,
  parameter int         VEC_W   = 8,
  parameter logic [7:0] VEC_MULTI = 8'h30,
  parameter logic [7:0] VEC_BASE  = 8'h31
) (
  input  logic [N_LINES-1:0] enab,
  output logic [VEC_W-1:0]   vec
);
  localparam int SCAN  = N_LINES - 1;
  localparam int CNT_W = $clog2(N_LINES + 1);

  logic [CNT_W-1:0] cnt;
  logic [VEC_W-1:0] first;
  logic             unused_top;
  assign unused_top = enab[N_LINES-1];

  always_comb begin
    cnt   = '0;
    first = '0;
    for (int i = SCAN - 1; i >= 0; i--) begin
      if (enab[i]) begin
        cnt   = cnt + 1'b1;
        first = VEC_W'(i);
      end
    end
    if (cnt == '0)      vec = '0;
    else if (cnt > 1)   vec = VEC_W'(VEC_MULTI);
    else                vec = VEC_W'(VEC_BASE) + first;
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
  parameter int         N_LINES   = 32,
  parameter int         ADDR_W    = 5,
  parameter int         VEC_W     = 8,
  parameter int         NMI_FIRST = 30,
  parameter logic [7:0] VEC_MULTI = 8'h30,
  parameter logic [7:0] VEC_BASE  = 8'h31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_data,
  input  logic               rd_en,
  output logic [N_LINES-1:0] rd_data,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               nmi_req
);
  logic [N_LINES-1:0] raw_d, raw_q, nmi_d, nmi_q, mask_d, mask_q;
  logic [VEC_W-1:0]   vec_d;

  vic_src #(.N_LINES(N_LINES), .NMI_FIRST(NMI_FIRST)) u_src (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .raw_d(raw_d), .nmi_d(nmi_d), .raw_q(raw_q), .nmi_q(nmi_q)
  );

  vic_regs #(.DATA_W(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .raw_q(raw_q), .nmi_q(nmi_q),
    .mask_d(mask_d), .mask_q(mask_q), .rd_data(rd_data)
  );

  // Encode from next-state values so outputs land with the registers.
  vic_encode #(.N_LINES(N_LINES), .VEC_W(VEC_W),
               .VEC_MULTI(VEC_MULTI), .VEC_BASE(VEC_BASE)) u_enc (
    .enab(raw_d & mask_d), .vec(vec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_vec <= '0;
      irq_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      irq_vec <= vec_d;
      irq_req <= (vec_d != '0);
      nmi_req <= |nmi_d;
    end
  end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int         N_LINES  = 32,
  parameter int         ADDR_W   = 5,
  parameter int         VEC_W    = 8,
  parameter logic [7:0] VEC_BASE = 8'h31
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] irq_in,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [N_LINES-1:0] wr_data,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               nmi_req,
  input logic [N_LINES-1:0] raw_q,
  input logic [N_LINES-1:0] mask_q
);
  logic [N_LINES-2:0] enab;
  assign enab = raw_q[N_LINES-2:0] & mask_q[N_LINES-2:0];

  a_r5_none_idle: assert property (@(posedge clk) disable iff (rst)
    (enab == '0) |-> (irq_vec == '0 && !irq_req));

  a_r6_single_own: assert property (@(posedge clk) disable iff (rst)
    ($countones(enab) == 1) |->
      (irq_req && irq_vec >= VEC_W'(VEC_BASE) && enab[5'(irq_vec - VEC_W'(VEC_BASE))]));

  a_r7_multi_shared: assert property (@(posedge clk) disable iff (rst)
    ($countones(enab) > 1) |-> (irq_vec == 8'h30 && irq_req));

  a_r8_raw_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (raw_q[N_LINES-4:0] == $past(irq_in[N_LINES-3:1])));

  a_r9_nmi_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (nmi_req == $past(|irq_in[N_LINES-1:N_LINES-2])));

  a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0) |=> (mask_q == $past(wr_data)));

  a_r2_other_ignored: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == '0) |=> $stable(mask_q));
endmodule

bind vic_ctrl vic_ctrl_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
                             .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req),
  .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] irq_in = '0;
  logic [4:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 0;
  logic [31:0] rd_data;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        nmi_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vic_ctrl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference state
  int unsigned m_mask = 0, m_raw = 0, m_nmi = 0, m_rd = 0;

  function automatic int unsigned exp_vec(int unsigned en);
    int n = 0;
    int pos = 0;
    for (int b = 0; b < 31; b++)
      if ((en >> b) & 1) begin
        if (n == 0) pos = b;
        n++;
      end
    if (n == 0) return 0;
    if (n > 1) return 'h30;
    return 'h31 + pos;
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int unsigned rv;
    if (rst) begin
      m_mask = 0; m_raw = 0; m_nmi = 0; m_rd = 0;
    end else begin
      rv = 0;
      if (addr[1:0] == 0)
        case (addr[4:2])
          0: rv = m_mask;
          1: rv = m_raw;
          2: rv = m_raw & m_mask;
          3: rv = m_nmi;
          default: rv = 0;
        endcase
      m_rd = rd_en ? rv : 0;
      if (wr_en && addr == 0) m_mask = wr_data;
      m_raw = 0;
      for (int n = 1; n <= 29; n++) if (irq_in[n]) m_raw |= (1 << (n - 1));
      m_nmi = irq_in & 32'hC000_0000;
    end
    #1;
    if (!done) begin
      check("R5/R6/R7 vector", irq_vec, exp_vec(m_raw & m_mask));
      check("R5/R6/R7 request", irq_req, exp_vec(m_raw & m_mask) != 0);
      check("R9 nmi", nmi_req, m_nmi != 0);
      check("R3 rd_data", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0; addr = '0;
    d = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 vec", irq_vec, 0);
    check("R1 req", irq_req, 0);
    check("R1 nmi", nmi_req, 0);
    rd(5'd0, v); check("R1 mask", v, 0);
    // R8 line 5 -> raw bit 4, masked off so no request
    irq_in = 32'h20;
    @(negedge clk);
    check("R5 masked off", irq_req, 0);
    rd(5'd4, v); check("R8 raw bit4", v, 32'h10);
    rd(5'd8, v); check("R4 enab none", v, 0);
    // R6 and R10: mask write shows on the following cycle only
    addr = 0; wr_data = 32'hFFFF_FFFF; wr_en = 1;
    #1 check("R10 before edge", irq_vec, 0);
    @(negedge clk); wr_en = 0;
    check("R6 single 0x35", irq_vec, 8'h35);
    check("R10 after edge", irq_req, 1);
    // R7 two sources
    irq_in = 32'h220;
    @(negedge clk);
    check("R7 shared", irq_vec, 8'h30);
    rd(5'd8, v); check("R4 enab", v, 32'h110);
    wr(5'd0, 32'h100);
    check("R6 masked to bit8", irq_vec, 8'h39);
    // R6 top of scan: line 29
    wr(5'd0, 32'hFFFF_FFFF);
    irq_in = 32'h2000_0000;
    @(negedge clk);
    check("R6 line29", irq_vec, 8'h4D);
    // R8 line 0 ignored
    irq_in = 32'h1;
    @(negedge clk);
    check("R8 line0 vec", irq_vec, 0);
    rd(5'd4, v); check("R8 line0 raw", v, 0);
    // R9 non-maskable lines ignore mask
    wr(5'd0, 32'h0);
    irq_in = 32'h4000_0000;
    @(negedge clk);
    check("R9 nmi line30", nmi_req, 1);
    check("R9 no irq", irq_req, 0);
    irq_in = 32'hC000_0000;
    @(negedge clk);
    rd(5'd12, v); check("R9 status", v, 32'hC000_0000);
    irq_in = 0;
    @(negedge clk);
    check("R9 nmi clear", nmi_req, 0);
    // R2 writes elsewhere are ignored
    wr(5'd0, 32'h0000_00F0);
    wr(5'd4, 32'hFFFF_FFFF);
    wr(5'd1, 32'hFFFF_FFFF);
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd0, v); check("R2 mask kept", v, 32'h0000_00F0);
    rd(5'd4, v); check("R2 raw kept", v, 0);
    // R3 diag and out-of-map reads
    rd(5'd16, v); check("R3 diag", v, 0);
    rd(5'd20, v); check("R3 unmapped", v, 0);
    rd(5'd2, v);  check("R3 misaligned", v, 0);
    // Mixed traffic against the reference model
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      irq_in = (k % 3 == 0) ? (32'h1 << lfsr[4:0]) : lfsr;
      addr = lfsr[9:5];
      rd_en = lfsr[10];
      wr_en = lfsr[11] & lfsr[12];
      wr_data = {lfsr[15:0], lfsr[31:16]};
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule